// File: doc/BRIEF.md
# Multichannel Supply Trim Control Sequencer

This block is the digital controller behind closed-loop trimming of several DC/DC converter outputs. One shared sense path is time-shared: a scheduler visits the channels in fixed round-robin order. For each visit it presents the channel index and that channel's selected target code to an external comparator. It then reads back a three-way result and turns it into a raise pulse, a lower pulse, or no pulse on that channel's trim drive.

Each channel holds three setpoint codes: nominal, margin high and margin low. Two command bits per channel choose which of them is the target. Margin selection has effect only on a channel whose control is enabled.

A polarity-programmable start input enables the whole controller. A halt input, raised by the serial interface while it owns the bus, freezes all sequencing. An optional fast mode stretches correction pulses until a channel first lands in band. Per-channel status bits feed a frame-synchronous, polarity-programmable, open-drain ready output.

Top module: `trim_seq_top`

## Requirements
- R1: `visit_ch` steps through 0..NCH-1 and wraps. Each visit lasts SLOT_TICKS ticks of a prescaler that ticks every DIV clocks, so a frame is NCH*SLOT_TICKS*DIV clocks long.
- R2: At the end of a visit `cmp_i` is decoded: 2'b01 (sense below target) starts a raise pulse on `trim_up`, and 2'b10 (sense above target) starts a lower pulse on `trim_dn`. 2'b00 and 2'b11 (in band) start no pulse. A pulse begins the clock after the evaluation and lasts NORM_TICKS*DIV clocks.
- R3: For the visited channel, `tgt_code` is taken from the setpoints by the channel's two command bits (bits 2c+1:2c). 00 selects nominal, 01 margin high, 10 margin low and 11 nominal. A channel whose `chan_en` bit is low always yields its nominal code.
- R4: A channel's `status_o` bit is set by an in-band evaluation and cleared by an out-of-band one.
- R5: A change of a channel's command bits clears its status bit on the next clock. `rdy_level` then leaves its asserted level no later than the next frame boundary.
- R6: At each frame boundary the ready state is recomputed as true when every enabled channel's status bit is set. `rdy_level` equals `rdy_pol` while ready and its inverse otherwise. `rdy_pull_low` is high exactly when `rdy_level` is low.
- R7: A channel that is disabled, or any channel while start is inactive, has `trim_oe` low, issues no pulse and keeps its status bit clear.
- R8: Start is active when `start_i` equals `start_pol`. While it is inactive, the scheduler holds its position and ready is deasserted.
- R9: With `fast_en` set, a channel that has not been in band since its last command change or enable issues pulses of NORM_TICKS*FAST_MULT*DIV clocks. After its first in-band result it returns to normal width.
- R10: While `halt_i` is high, the scheduler position, the prescaler and all pulse timers hold. Sequencing resumes where it stopped.
- R11: After reset, `trim_up`, `trim_dn`, `trim_oe` and `status_o` are zero, `visit_ch` is 0, and ready is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Control enable input |
| start_pol | input | 1 | Level of `start_i` that means active |
| halt_i | input | 1 | Freeze request from the serial interface |
| fast_en | input | 1 | Fast-convergence enable |
| rdy_pol | input | 1 | Asserted level of the ready output |
| chan_en | input | NCH | Per-channel control enable |
| cmd_i | input | 2*NCH | Per-channel target select, two bits each |
| sp_nom | input | NCH*CW | Nominal setpoint codes |
| sp_hi | input | NCH*CW | Margin-high setpoint codes |
| sp_lo | input | NCH*CW | Margin-low setpoint codes |
| cmp_i | input | 2 | Comparator result for the visited channel |
| visit_ch | output | CHW | Channel currently on the sense path |
| tgt_code | output | CW | Target code of the visited channel |
| trim_up | output | NCH | Raise pulses |
| trim_dn | output | NCH | Lower pulses |
| trim_oe | output | NCH | Trim drive enable; low means high impedance |
| status_o | output | NCH | Per-channel at-setpoint bits |
| rdy_level | output | 1 | Ready pin level after polarity |
| rdy_pull_low | output | 1 | Open-drain pull-down enable for the ready pin |

## Verification
A slot or prescaler count that slips shows first as a `visit_ch` step on the wrong clock within one frame, and as a pulse whose measured width is off by whole ticks. A wrong convergence flag appears on the very next visit of that channel as a fast-width pulse where a normal one is due, or the other way round. A status bit that fails to clear after a command change shows up as a ready level that survives the following frame boundary. A halt leak moves `visit_ch` within a few clocks of the freeze.

// File: rtl/trim_seq_pkg.sv
package trim_seq_pkg;

    typedef enum logic [1:0] {
        CMP_BAND     = 2'b00,
        CMP_LOW      = 2'b01,
        CMP_HIGH     = 2'b10,
        CMP_BAND_ALT = 2'b11
    } cmp_e;

    typedef enum logic [1:0] {
        SEL_NOM     = 2'b00,
        SEL_HI      = 2'b01,
        SEL_LO      = 2'b10,
        SEL_NOM_ALT = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'b00,
        ACT_RAISE = 2'b01,
        ACT_LOWER = 2'b10
    } act_e;

    typedef struct packed {
        logic active;
        logic tick;
        logic eval;
        logic cmd_chg;
        logic fast;
    } chan_ctl_t;

    function automatic act_e decide(input cmp_e c);
        case (c)
            CMP_LOW:  return ACT_RAISE;
            CMP_HIGH: return ACT_LOWER;
            default:  return ACT_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/trim_sched.sv
module trim_sched #(
    parameter int NCH        = 6,
    parameter int DIV        = 4,
    parameter int SLOT_TICKS = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int DW  = (DIV > 1) ? $clog2(DIV) : 1,
    localparam int TW  = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    output logic           tick,
    output logic           eval,
    output logic           frame_end,
    output logic [CHW-1:0] ch
);
    logic [DW-1:0] pre;
    logic [TW-1:0] tk;

    assign tick      = run && (pre == DW'(DIV - 1));
    assign eval      = tick && (tk == TW'(SLOT_TICKS - 1));
    assign frame_end = eval && (ch == CHW'(NCH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= '0;
            tk  <= '0;
            ch  <= '0;
        end else if (run) begin
            pre <= tick ? '0 : pre + 1'b1;
            if (eval) begin
                tk <= '0;
                ch <= frame_end ? '0 : ch + 1'b1;
            end else if (tick) begin
                tk <= tk + 1'b1;
            end
        end
    end
endmodule

// File: rtl/trim_chan.sv
module trim_chan
    import trim_seq_pkg::*;
#(
    parameter int NORM_TICKS = 1,
    parameter int FAST_MULT  = 10,
    localparam int FAST_TICKS = NORM_TICKS * FAST_MULT,
    localparam int PW = $clog2(FAST_TICKS + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  chan_ctl_t ctl,
    input  logic [1:0] cmp,
    output logic      up,
    output logic      dn,
    output logic      oe,
    output logic      status
);
    logic [PW-1:0] left;
    logic [PW-1:0] width;
    logic          dir_up;
    logic          conv;
    act_e          act;

    assign act   = decide(cmp_e'(cmp));
    assign width = (ctl.fast && !conv) ? PW'(FAST_TICKS) : PW'(NORM_TICKS);

    always_ff @(posedge clk) begin
        if (rst || !ctl.active) begin
            left   <= '0;
            dir_up <= 1'b0;
            conv   <= 1'b0;
            status <= 1'b0;
            oe     <= 1'b0;
        end else begin
            oe <= 1'b1;
            if (ctl.eval) begin
                case (act)
                    ACT_RAISE: begin
                        left   <= width;
                        dir_up <= 1'b1;
                        status <= 1'b0;
                    end
                    ACT_LOWER: begin
                        left   <= width;
                        dir_up <= 1'b0;
                        status <= 1'b0;
                    end
                    default: begin
                        left   <= '0;
                        status <= 1'b1;
                        conv   <= 1'b1;
                    end
                endcase
            end else if (ctl.tick && left != '0) begin
                left <= left - 1'b1;
            end
            if (ctl.cmd_chg) begin
                status <= 1'b0;
                conv   <= 1'b0;
            end
        end
    end

    assign up = oe && (left != '0) && dir_up;
    assign dn = oe && (left != '0) && !dir_up;
endmodule

// File: rtl/trim_ready.sv
module trim_ready #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_act,
    input  logic           frame_end,
    input  logic           rdy_pol,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] status,
    output logic           rdy_level,
    output logic           rdy_pull_low
);
    logic fe_d;
    logic rdy_q;

    always_ff @(posedge clk) begin
        if (rst || !start_act) begin
            fe_d  <= 1'b0;
            rdy_q <= 1'b0;
        end else begin
            fe_d <= frame_end;
            if (fe_d) begin
                rdy_q <= &(status | ~en);
            end
        end
    end

    assign rdy_level    = rdy_q ? rdy_pol : !rdy_pol;
    assign rdy_pull_low = !rdy_level;
endmodule

// File: rtl/trim_seq_top.sv
module trim_seq_top
    import trim_seq_pkg::*;
#(
    parameter int NCH        = 6,
    parameter int CW         = 10,
    parameter int DIV        = 1000,
    parameter int SLOT_TICKS = 4,
    parameter int NORM_TICKS = 1,
    parameter int FAST_MULT  = 10,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              start_pol,
    input  logic              halt_i,
    input  logic              fast_en,
    input  logic              rdy_pol,
    input  logic [NCH-1:0]    chan_en,
    input  logic [2*NCH-1:0]  cmd_i,
    input  logic [NCH*CW-1:0] sp_nom,
    input  logic [NCH*CW-1:0] sp_hi,
    input  logic [NCH*CW-1:0] sp_lo,
    input  logic [1:0]        cmp_i,
    output logic [CHW-1:0]    visit_ch,
    output logic [CW-1:0]     tgt_code,
    output logic [NCH-1:0]    trim_up,
    output logic [NCH-1:0]    trim_dn,
    output logic [NCH-1:0]    trim_oe,
    output logic [NCH-1:0]    status_o,
    output logic              rdy_level,
    output logic              rdy_pull_low
);
    logic             start_act;
    logic             run;
    logic             tick;
    logic             eval;
    logic             frame_end;
    logic [2*NCH-1:0] cmd_q;
    logic [CW-1:0]    tgt_all [NCH];

    assign start_act = (start_i == start_pol);
    assign run       = start_act && !halt_i;

    always_ff @(posedge clk) begin
        cmd_q <= cmd_i;
    end

    trim_sched #(
        .NCH(NCH), .DIV(DIV), .SLOT_TICKS(SLOT_TICKS)
    ) u_sched (
        .clk(clk), .rst(rst), .run(run),
        .tick(tick), .eval(eval), .frame_end(frame_end), .ch(visit_ch)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_ctl_t ctl;
        sel_e      sel;

        assign sel = sel_e'(cmd_i[2*c +: 2]);

        always_comb begin
            if (!chan_en[c]) begin
                tgt_all[c] = sp_nom[c*CW +: CW];
            end else begin
                case (sel)
                    SEL_HI:  tgt_all[c] = sp_hi[c*CW +: CW];
                    SEL_LO:  tgt_all[c] = sp_lo[c*CW +: CW];
                    default: tgt_all[c] = sp_nom[c*CW +: CW];
                endcase
            end
        end

        assign ctl.active  = chan_en[c] && start_act;
        assign ctl.tick    = tick;
        assign ctl.eval    = eval && (visit_ch == CHW'(c));
        assign ctl.cmd_chg = (cmd_i[2*c +: 2] != cmd_q[2*c +: 2]);
        assign ctl.fast    = fast_en;

        trim_chan #(
            .NORM_TICKS(NORM_TICKS), .FAST_MULT(FAST_MULT)
        ) u_chan (
            .clk(clk), .rst(rst), .ctl(ctl), .cmp(cmp_i),
            .up(trim_up[c]), .dn(trim_dn[c]), .oe(trim_oe[c]), .status(status_o[c])
        );
    end

    always_comb begin
        tgt_code = '0;
        for (int c = 0; c < NCH; c++) begin
            if (visit_ch == CHW'(c)) tgt_code = tgt_all[c];
        end
    end

    trim_ready #(.NCH(NCH)) u_ready (
        .clk(clk), .rst(rst), .start_act(start_act), .frame_end(frame_end),
        .rdy_pol(rdy_pol), .en(chan_en), .status(status_o),
        .rdy_level(rdy_level), .rdy_pull_low(rdy_pull_low)
    );
endmodule

// File: rtl/trim_seq_chk.sv
module trim_seq_chk #(
    parameter int NCH = 6,
    parameter int CHW = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             start_pol,
    input logic             halt_i,
    input logic             rdy_pol,
    input logic [2*NCH-1:0] cmd_i,
    input logic [CHW-1:0]   visit_ch,
    input logic [NCH-1:0]   trim_up,
    input logic [NCH-1:0]   trim_dn,
    input logic [NCH-1:0]   trim_oe,
    input logic [NCH-1:0]   status_o,
    input logic             rdy_level
);
    AST_UP_DN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (trim_up & trim_dn) == '0) else $error("raise and lower together"); // R2

    AST_PULSE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        ((trim_up | trim_dn) & ~trim_oe) == '0) else $error("pulse while undriven"); // R7

    AST_HALT_FREEZES_SLOT: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> $stable(visit_ch)) else $error("scheduler moved under halt"); // R10

    AST_STOP_RELEASES_TRIM: assert property (@(posedge clk) disable iff (rst)
        (start_i != start_pol) |=> (trim_oe == '0)) else $error("trim driven while stopped"); // R7

    AST_STOP_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (start_i != start_pol) |=> (rdy_level != rdy_pol)) else $error("ready while stopped"); // R8

    for (genvar c = 0; c < NCH; c++) begin : g_cmd
        AST_CMD_CLEARS_STATUS: assert property (@(posedge clk) disable iff (rst)
            (cmd_i[2*c +: 2] != $past(cmd_i[2*c +: 2])) |=> !status_o[c])
            else $error("status kept after command change"); // R5
    end
endmodule

bind trim_seq_top trim_seq_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .start_pol(start_pol),
    .halt_i(halt_i), .rdy_pol(rdy_pol), .cmd_i(cmd_i), .visit_ch(visit_ch),
    .trim_up(trim_up), .trim_dn(trim_dn), .trim_oe(trim_oe),
    .status_o(status_o), .rdy_level(rdy_level)
);

// File: tb/sim_trim_seq_top.sv
module sim_trim_seq_top;
    localparam int NCH   = 6;
    localparam int CW    = 10;
    localparam int DIV   = 2;
    localparam int SLOT  = 3;
    localparam int NORM  = 1;
    localparam int MULT  = 4;
    localparam int CHW   = 3;
    localparam int SLOTC = SLOT * DIV;
    localparam int FRAME = NCH * SLOTC;
    localparam int NW    = NORM * DIV;
    localparam int FW    = NORM * MULT * DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, start_pol = 1'b1, halt_i = 1'b0, fast_en = 1'b0, rdy_pol = 1'b1;
    logic [NCH-1:0]    chan_en = '1;
    logic [2*NCH-1:0]  cmd_i = '0;
    logic [NCH*CW-1:0] sp_nom, sp_hi, sp_lo;
    logic [1:0]        cmp_i;
    logic [CHW-1:0]    visit_ch;
    logic [CW-1:0]     tgt_code;
    logic [NCH-1:0]    trim_up, trim_dn, trim_oe, status_o;
    logic              rdy_level, rdy_pull_low;
    logic [CW-1:0]     plant [NCH];

    int vectors = 0;
    int fails   = 0;

    typedef struct { int ch; int dir; int width; string tag; } exp_t;
    exp_t exp_q[$];
    int wcnt [NCH];
    int wdir [NCH];

    always #4 clk = ~clk;

    function automatic int nomv(input int c); return 100 + 10 * c; endfunction
    function automatic int hiv(input int c);  return nomv(c) + 20;  endfunction
    function automatic int lov(input int c);  return nomv(c) - 20;  endfunction

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            sp_nom[c*CW +: CW] = CW'(nomv(c));
            sp_hi[c*CW +: CW]  = CW'(hiv(c));
            sp_lo[c*CW +: CW]  = CW'(lov(c));
        end
    end

    // comparator model: 00 in band, 01 sense below target, 10 sense above target
    always_comb begin
        cmp_i = 2'b00;
        for (int c = 0; c < NCH; c++) begin
            if (int'(visit_ch) == c) begin
                if (plant[c] < tgt_code)      cmp_i = 2'b01;
                else if (plant[c] > tgt_code) cmp_i = 2'b10;
            end
        end
    end

    trim_seq_top #(
        .NCH(NCH), .CW(CW), .DIV(DIV), .SLOT_TICKS(SLOT),
        .NORM_TICKS(NORM), .FAST_MULT(MULT)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .start_pol(start_pol),
        .halt_i(halt_i), .fast_en(fast_en), .rdy_pol(rdy_pol), .chan_en(chan_en),
        .cmd_i(cmd_i), .sp_nom(sp_nom), .sp_hi(sp_hi), .sp_lo(sp_lo), .cmp_i(cmp_i),
        .visit_ch(visit_ch), .tgt_code(tgt_code), .trim_up(trim_up), .trim_dn(trim_dn),
        .trim_oe(trim_oe), .status_o(status_o), .rdy_level(rdy_level),
        .rdy_pull_low(rdy_pull_low)
    );

    task automatic chk(input string req, input int act, input int expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push(input int ch, input int dir, input int width, input string tag);
        exp_t e;
        e.ch = ch; e.dir = dir; e.width = width; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic sync();
        do @(negedge clk); while (int'(visit_ch) != NCH - 1);
        do @(negedge clk); while (int'(visit_ch) != 0);
    endtask

    task automatic settle_ready();
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_visit(input int c);
        do @(negedge clk); while (int'(visit_ch) != c);
    endtask

    // monitor: measures every pulse and compares it with the next expected item
    initial begin
        for (int c = 0; c < NCH; c++) begin wcnt[c] = 0; wdir[c] = 0; end
        forever begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                if (trim_up[c] || trim_dn[c]) begin
                    wcnt[c]++;
                    wdir[c] = trim_up[c] ? 1 : 2;
                end else if (wcnt[c] != 0) begin
                    vectors++;
                    if (exp_q.size() == 0) begin
                        fails++;
                        $display("FAIL R2 unexpected pulse: actual ch%0d dir%0d width%0d expected none",
                                 c, wdir[c], wcnt[c]);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        if (e.ch != c || e.dir != wdir[c] || e.width != wcnt[c]) begin
                            fails++;
                            $display("FAIL %s: actual ch%0d dir%0d width%0d expected ch%0d dir%0d width%0d",
                                     e.tag, c, wdir[c], wcnt[c], e.ch, e.dir, e.width);
                        end
                    end
                    wcnt[c] = 0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int errs;
        int vc;
        for (int c = 0; c < NCH; c++) plant[c] = CW'(nomv(c));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 oe", int'(trim_oe), 0);
        chk("R11 pulses", int'(trim_up | trim_dn), 0);
        chk("R11 status", int'(status_o), 0);
        chk("R11 visit", int'(visit_ch), 0);
        chk("R11 ready level", int'(rdy_level), 0);
        chk("R11 pull low", int'(rdy_pull_low), 1);

        start_i = 1'b1;
        sync();
        // R1 order and frame length
        errs = 0;
        for (int k = 0; k < FRAME; k++) begin
            if (int'(visit_ch) != k / SLOTC) errs++;
            @(negedge clk);
        end
        chk("R1 slot order", errs, 0);
        chk("R1 wrap", int'(visit_ch), 0);
        sync();
        chk("R4 all in band", int'(status_o), 63);
        settle_ready();
        chk("R6 ready high", int'(rdy_level), 1);
        chk("R6 pull released", int'(rdy_pull_low), 0);

        // R2 raise and lower
        sync();
        plant[0] = CW'(nomv(0) - 5);
        plant[1] = CW'(nomv(1) + 5);
        for (int f = 0; f < 2; f++) begin
            push(0, 1, NW, "R2 raise");
            push(1, 2, NW, "R2 lower");
        end
        sync();
        sync();
        chk("R2 queue drained", exp_q.size(), 0);
        chk("R4 out of band cleared", int'(status_o), 6'b111100);
        settle_ready();
        chk("R6 ready low", int'(rdy_level), 0);
        plant[0] = CW'(nomv(0));
        plant[1] = CW'(nomv(1));
        sync();
        chk("R4 back in band", int'(status_o), 63);

        // R3 / R5 margin high on channel 2
        cmd_i[5:4] = 2'b01;
        push(2, 1, NW, "R3 margin high raise");
        @(negedge clk);
        chk("R5 status cleared", int'(status_o[2]), 0);
        wait_visit(2);
        chk("R3 high code", int'(tgt_code), hiv(2));
        sync();
        settle_ready();
        chk("R5 ready dropped", int'(rdy_level), 0);
        push(2, 1, NW, "R3 margin high raise");
        sync();
        plant[2] = CW'(hiv(2));
        sync();
        chk("R4 at margin high", int'(status_o[2]), 1);
        cmd_i[5:4] = 2'b10;
        plant[2] = CW'(lov(2));
        wait_visit(2);
        chk("R3 low code", int'(tgt_code), lov(2));
        sync();
        sync();
        chk("R4 at margin low", int'(status_o[2]), 1);
        cmd_i[5:4] = 2'b11;
        plant[2] = CW'(nomv(2));
        wait_visit(2);
        chk("R3 code 11 nominal", int'(tgt_code), nomv(2));
        sync();
        cmd_i[5:4] = 2'b00;
        sync();
        chk("R2 queue drained", exp_q.size(), 0);

        // R9 fast convergence on channel 3
        fast_en = 1'b1;
        cmd_i[7:6] = 2'b10;
        push(3, 2, FW, "R9 fast lower");
        push(3, 2, FW, "R9 fast lower");
        sync();
        sync();
        plant[3] = CW'(lov(3));
        sync();
        chk("R9 converged", int'(status_o[3]), 1);
        plant[3] = CW'(lov(3) + 5);
        push(3, 2, NW, "R9 normal after converge");
        sync();
        plant[3] = CW'(lov(3));
        sync();
        cmd_i[7:6] = 2'b00;
        fast_en = 1'b0;
        plant[3] = CW'(nomv(3));
        sync();
        chk("R9 queue drained", exp_q.size(), 0);

        // R7 / R3 disabled channel 4
        chan_en[4] = 1'b0;
        cmd_i[9:8] = 2'b01;
        plant[4] = CW'(nomv(4) + 7);
        wait_visit(4);
        chk("R3 disabled uses nominal", int'(tgt_code), nomv(4));
        sync();
        sync();
        chk("R7 disabled oe", int'(trim_oe[4]), 0);
        chk("R7 disabled status", int'(status_o[4]), 0);
        settle_ready();
        chk("R6 ready ignores disabled", int'(rdy_level), 1);
        chan_en[4] = 1'b1;
        cmd_i[9:8] = 2'b00;
        plant[4] = CW'(nomv(4));
        sync();
        chk("R7 re-enabled oe", int'(trim_oe[4]), 1);

        // R10 halt
        sync();
        halt_i = 1'b1;
        plant[0] = CW'(nomv(0) - 5);
        errs = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (int'(visit_ch) != 0 || trim_up[0]) errs++;
        end
        chk("R10 frozen", errs, 0);
        push(0, 1, NW, "R10 resume pulse");
        halt_i = 1'b0;
        sync();
        plant[0] = CW'(nomv(0));
        sync();
        chk("R10 queue drained", exp_q.size(), 0);

        // R8 start polarity
        sync();
        start_pol = 1'b0;
        plant[1] = CW'(nomv(1) + 5);
        @(negedge clk);
        vc = int'(visit_ch);
        repeat (40) @(negedge clk);
        chk("R8 scheduler held", int'(visit_ch), vc);
        chk("R7 stopped oe", int'(trim_oe), 0);
        chk("R7 stopped status", int'(status_o), 0);
        chk("R8 ready dropped", int'(rdy_level), 0);
        start_pol = 1'b1;
        plant[1] = CW'(nomv(1));
        sync();
        sync();
        chk("R8 restarted status", int'(status_o), 63);
        settle_ready();
        chk("R8 restarted ready", int'(rdy_level), 1);

        // R6 active-low ready
        rdy_pol = 1'b0;
        @(negedge clk);
        chk("R6 active low level", int'(rdy_level), 0);
        chk("R6 active low pull", int'(rdy_pull_low), 1);

        chk("R2 final queue", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule